// File: doc/BRIEF.md
# Bus Phantom and Power-On-Jump Controller

This block decides when a single-board CPU card pulls the shared backplane PHANTOM line. That line is active low. While it is asserted, every other memory card on the bus stays off the data bus. The block watches the CPU's memory-request strobe and address. It raises a drive-enable for an external buffer whose data input is tied low. When the enable is low, the buffer floats and any other card may pull the line. The block also produces an onboard-select strobe that tells the card's own ROM and RAM they have been addressed.

Two sources can raise PHANTOM. The first is a power-on-jump latch. When its strap is on, reset sets the latch, so the CPU's first fetches come from the onboard boot ROM and any co-addressed RAM elsewhere stays silent. The first onboard memory request clears the latch once that request ends, and only another reset can set it again. When the strap is off, reset clears the latch. The second source is a live decode of onboard address windows, qualified by the request. A master strap gates both sources.

An extra-shadow window, sized 1, 2 or 4 KB, can be placed inside the main 4 KB window. Addresses inside the shadow window still raise PHANTOM, but they withhold onboard-select, so another card's ROM can answer there.

Top module: `phantom_ctrl`

## Requirements
- R1: While reset is active, onboard_sel is 0 and phantom_oe equals phantom_en AND poj_en.
- R2: With poj_en set at reset, phantom_oe stays 1 through any number of requests to addresses outside the onboard windows.
- R3: The latch releases only after a qualified onboard request ends. phantom_oe stays 1 in the first cycle after the internal request drops, and falls one cycle later.
- R4: Once released, the latch stays clear until the next reset. Later off-board requests give phantom_oe = 0.
- R5: With poj_en clear at reset, phantom_oe is 0 after reset until a qualified onboard request is in progress.
- R6: With phantom_en = 0, phantom_oe is 0 whatever the latch or decode. onboard_sel keeps working.
- R7: The onboard windows are 0xE000–0xEFFF and 0xFF00–0xFFFF. During a request to either window, onboard_sel = 1 and phantom_oe = 1 (with phantom_en = 1 and the shadow window off).
- R8: An address held in an onboard window with no request (mreq_n = 1) gives onboard_sel = 0 and no decode-driven PHANTOM. The request is seen two clock edges after mreq_n falls, and it ends two edges after mreq_n rises.
- R9: shd_size codes are 0 off, 1 for 1 KB, 2 for 2 KB and 3 for 4 KB. shd_base gives address bits [15:10] of the shadow window. Its low 0, 1 or 2 bits are ignored, so the window aligns to its own size. Inside both the shadow window and 0xE000–0xEFFF, a request gives phantom_oe = 1 and onboard_sel = 0. A shadow window placed outside 0xE000–0xEFFF has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases on the clock |
| mreq_n | input | 1 | Active-low memory-request strobe from the CPU (asynchronous) |
| addr | input | 16 | CPU address bus |
| phantom_en | input | 1 | Master strap allowing PHANTOM to be driven |
| poj_en | input | 1 | Strap choosing whether reset sets the power-on-jump latch |
| shd_size | input | 2 | Shadow window size code |
| shd_base | input | 6 | Shadow window base, address bits [15:10] |
| phantom_oe | output | 1 | Drive-enable for the low-driving PHANTOM buffer; 0 floats the line |
| onboard_sel | output | 1 | Onboard ROM/RAM selected by a qualified request |

## Verification
The assertions assume that the straps do not change during the last clock of reset. They also assume that mreq_n is clean at clock resolution, so that the value sampled two edges earlier explains the request the block sees now. The stimulus changes straps only while the request is idle or before reset is released. It drives mreq_n and addr only on falling clock edges. During the address sweeps mreq_n is held low, and only the address moves.

// File: rtl/phc_pkg.sv
package phc_pkg;

  typedef enum logic [1:0] {
    SHD_OFF = 2'd0,
    SHD_1K  = 2'd1,
    SHD_2K  = 2'd2,
    SHD_4K  = 2'd3
  } shd_size_e;

  // Bits of the shadow base that take part in the compare, per size code
  function automatic logic [31:0] shd_keep(input shd_size_e s);
    case (s)
      SHD_1K:  return 32'hFFFF_FFFF;
      SHD_2K:  return 32'hFFFF_FFFE;
      SHD_4K:  return 32'hFFFF_FFFC;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/phc_rst_sync.sv
module phc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_act
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_act = ~chain[STAGES-1];
endmodule

// File: rtl/phc_req_sync.sv
module phc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_act,
  input  logic mreq_n,
  output logic req,
  output logic req_end
);
  logic [STAGES-1:0] sync;
  logic              req_d;

  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act) begin
      sync  <= '0;
      req_d <= 1'b0;
    end else begin
      sync  <= {sync[STAGES-2:0], ~mreq_n};
      req_d <= sync[STAGES-1];
    end
  end

  assign req     = sync[STAGES-1];
  assign req_end = req_d & ~sync[STAGES-1];
endmodule

// File: rtl/phc_addr_decode.sv
module phc_addr_decode
  import phc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                NWIN     = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{16'hE000, 16'hFF00},
  parameter int                WIN_LG   [NWIN] = '{12, 8},
  parameter int                SHD_HOST = 0,
  parameter int                SHD_LG   = 10,
  localparam int               BASE_W   = ADDR_W - SHD_LG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        shd_size,
  input  logic [BASE_W-1:0] shd_base,
  output logic              prim_hit,
  output logic              shd_hit
);
  logic [NWIN-1:0] win_hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << WIN_LG[i];
    assign win_hit[i] = ((addr ^ WIN_BASE[i]) & KEEP) == '0;
  end

  shd_size_e         size_code;
  logic [BASE_W-1:0] keep_bits;
  logic              shd_match;

  always_comb begin
    size_code = shd_size_e'(shd_size);
    keep_bits = shd_keep(size_code)[BASE_W-1:0];
    shd_match = ((addr[ADDR_W-1:SHD_LG] ^ shd_base) & keep_bits) == '0;
  end

  assign prim_hit = |win_hit;
  assign shd_hit  = (size_code != SHD_OFF) && shd_match && win_hit[SHD_HOST];
endmodule

// File: rtl/phc_poj_latch.sv
module phc_poj_latch (
  input  logic clk,
  input  logic rst_act,
  input  logic poj_en,
  input  logic clr,
  output logic latch_q,
  output logic latch_on
);
  // Reset loads the strap value on every edge; the bypass covers the time
  // before the first edge, so the strap never needs an asynchronous load.
  always_ff @(posedge clk) begin
    if (rst_act)  latch_q <= poj_en;
    else if (clr) latch_q <= 1'b0;
  end

  assign latch_on = rst_act ? poj_en : latch_q;
endmodule

// File: rtl/phantom_ctrl.sv
module phantom_ctrl #(
  parameter int                ADDR_W      = 16,
  parameter int                NWIN        = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{16'hE000, 16'hFF00},
  parameter int                WIN_LG   [NWIN] = '{12, 8},
  parameter int                SHD_HOST    = 0,
  parameter int                SHD_LG      = 10,
  parameter int                SYNC_STAGES = 2,
  localparam int               BASE_W      = ADDR_W - SHD_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              phantom_en,
  input  logic              poj_en,
  input  logic [1:0]        shd_size,
  input  logic [BASE_W-1:0] shd_base,
  output logic              phantom_oe,
  output logic              onboard_sel
);
  logic rst_act;
  logic req;
  logic req_end;
  logic prim_hit;
  logic shd_hit;
  logic hit_q;
  logic latch_q;
  logic latch_on;

  phc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_act (rst_act)
  );

  phc_req_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk     (clk),
    .rst_act (rst_act),
    .mreq_n  (mreq_n),
    .req     (req),
    .req_end (req_end)
  );

  phc_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NWIN     (NWIN),
    .WIN_BASE (WIN_BASE),
    .WIN_LG   (WIN_LG),
    .SHD_HOST (SHD_HOST),
    .SHD_LG   (SHD_LG)
  ) u_dec (
    .addr     (addr),
    .shd_size (shd_size),
    .shd_base (shd_base),
    .prim_hit (prim_hit),
    .shd_hit  (shd_hit)
  );

  // Remember whether the request now ending targeted onboard space
  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act)  hit_q <= 1'b0;
    else if (req) hit_q <= prim_hit;
  end

  phc_poj_latch u_latch (
    .clk      (clk),
    .rst_act  (rst_act),
    .poj_en   (poj_en),
    .clr      (req_end & hit_q),
    .latch_q  (latch_q),
    .latch_on (latch_on)
  );

  assign phantom_oe  = phantom_en & (latch_on | (req & prim_hit));
  assign onboard_sel = req & prim_hit & ~shd_hit;
endmodule

// File: rtl/phc_checker.sv
module phc_checker (
  input logic clk,
  input logic rst_act,
  input logic mreq_n,
  input logic phantom_en,
  input logic phantom_oe,
  input logic onboard_sel,
  input logic req,
  input logic latch_q
);
  always_comb begin
    if (rst_act) begin
      p_quiet_in_reset_r1: assert (!onboard_sel);
    end
  end

  p_release_trailing_r3: assert property (@(posedge clk) disable iff (rst_act)
    $fell(latch_q) |-> !$past(req));

  p_latch_oneshot_r4: assert property (@(posedge clk) disable iff (rst_act)
    !$rose(latch_q));

  p_strap_gate_r6: assert property (@(posedge clk) disable iff (rst_act)
    !phantom_en |-> !phantom_oe);

  p_sel_drives_phantom_r7: assert property (@(posedge clk) disable iff (rst_act)
    (onboard_sel && phantom_en) |-> phantom_oe);

  p_sel_needs_request_r8: assert property (@(posedge clk) disable iff (rst_act)
    onboard_sel |-> !$past(mreq_n, 2));
endmodule

bind phantom_ctrl phc_checker u_chk (
  .clk         (clk),
  .rst_act     (rst_act),
  .mreq_n      (mreq_n),
  .phantom_en  (phantom_en),
  .phantom_oe  (phantom_oe),
  .onboard_sel (onboard_sel),
  .req         (req),
  .latch_q     (latch_q)
);

// File: tb/sim_phantom_ctrl.sv
`timescale 1ns/1ps
module sim_phantom_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreq_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        phantom_en = 1'b1;
  logic        poj_en = 1'b1;
  logic [1:0]  shd_size = 2'd0;
  logic [5:0]  shd_base = 6'd0;
  logic        phantom_oe;
  logic        onboard_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phantom_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .addr(addr),
    .phantom_en(phantom_en), .poj_en(poj_en), .shd_size(shd_size),
    .shd_base(shd_base), .phantom_oe(phantom_oe), .onboard_sel(onboard_sel)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%b expected=%b", tag, addr, got, exp);
    end
  endtask

  function automatic bit in_prim(input int a);
    return (a >= 'hE000 && a <= 'hEFFF) || (a >= 'hFF00 && a <= 'hFFFF);
  endfunction

  function automatic bit in_shd(input int a, input int sz, input int base);
    int blk;
    int start;
    if (sz == 0) return 1'b0;
    blk   = 1 << (sz - 1);
    start = (base / blk) * blk * 1024;
    return a >= start && a < start + blk * 1024 && a >= 'hE000 && a <= 'hEFFF;
  endfunction

  task automatic do_reset(input string tag);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({tag, " reset sel"}, onboard_sel, 1'b0);
    chk({tag, " reset phantom"}, phantom_oe, phantom_en & poj_en);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req_on(input logic [15:0] a);
    @(negedge clk); addr = a; mreq_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req_off();
    mreq_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    // R1: reset state with power-on-jump set
    do_reset("R1");

    // R2: off-board requests keep the latch asserted
    req_on(16'h1000);
    chk("R2 during", phantom_oe, 1'b1);
    chk("R2 sel", onboard_sel, 1'b0);
    req_off(); step();
    chk("R2 after", phantom_oe, 1'b1);
    req_on(16'h7FFF);
    chk("R2 second", phantom_oe, 1'b1);
    req_off(); step();

    // R3: release after the trailing edge of an onboard request
    req_on(16'hE000);
    chk("R3 sel", onboard_sel, 1'b1);
    chk("R3 during", phantom_oe, 1'b1);
    req_off();
    chk("R3 end cycle", phantom_oe, 1'b1);
    step();
    chk("R3 released", phantom_oe, 1'b0);

    // R4: one-shot per reset
    req_on(16'h2000);
    chk("R4 offboard", phantom_oe, 1'b0);
    req_off(); step();
    req_on(16'hFF10);
    chk("R4 onboard", phantom_oe, 1'b1);
    req_off(); step();
    req_on(16'h1000);
    chk("R4 stays clear", phantom_oe, 1'b0);
    req_off(); step();

    // R8: address in window but no request
    addr = 16'hE123; step(); step();
    chk("R8 no req sel", onboard_sel, 1'b0);
    chk("R8 no req phantom", phantom_oe, 1'b0);

    // R6: master strap off
    phantom_en = 1'b0;
    do_reset("R6");
    chk("R6 latch gated", phantom_oe, 1'b0);
    req_on(16'hE100);
    chk("R6 decode gated", phantom_oe, 1'b0);
    chk("R6 sel works", onboard_sel, 1'b1);
    req_off(); step();

    // R5: power-on-jump disabled
    phantom_en = 1'b1; poj_en = 1'b0;
    do_reset("R5");
    chk("R5 after reset", phantom_oe, 1'b0);
    req_on(16'h3000);
    chk("R5 offboard", phantom_oe, 1'b0);
    req_off(); step();
    req_on(16'hEFFF);
    chk("R5 onboard", phantom_oe, 1'b1);
    req_off(); step();
    chk("R5 idle", phantom_oe, 1'b0);

    // R7: full address sweep with the request held
    @(negedge clk); mreq_n = 1'b0;
    repeat (2) @(posedge clk);
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk); addr = a[15:0]; #1;
      chk("R7 sel", onboard_sel, in_prim(a));
      chk("R7 phantom", phantom_oe, in_prim(a));
    end

    // R9: shadow window sizes and placements
    for (int sz = 1; sz < 4; sz++) begin
      for (int k = 0; k < 3; k++) begin
        int b;
        b = (k == 0) ? 'h38 : (k == 1) ? 'h3B : 'h3E;
        @(negedge clk); shd_size = sz[1:0]; shd_base = b[5:0];
        for (int a = 0; a < 65536; a += 'h80) begin
          @(negedge clk); addr = a[15:0]; #1;
          chk("R9 sel", onboard_sel, in_prim(a) && !in_shd(a, sz, b));
          chk("R9 phantom", phantom_oe, in_prim(a));
        end
      end
    end
    @(negedge clk); mreq_n = 1'b1; shd_size = 2'd0;
    repeat (3) step();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #5ms;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule